// File: doc/BRIEF.md
# Serial Command and Status Port for a Voice Store Codec

This block is the host-facing control port of a voice store-and-replay codec. A host drives a serial clock, a data line and an active-low select. While select is low, the port shifts in 8-bit command bytes and the data bytes that follow them, most significant bit first, on rising serial clock edges. It keeps the codec mode settings, assembles a status byte, and returns that byte on a reply line with an output enable. All serial pins are brought into the system clock domain through two-flop synchronizers.

Page transfer and wait requests go to the command sequencer through a one-entry command buffer with a valid/ready handshake. A command is offered on `cmd_valid_o` and held with stable contents until the sequencer takes it by raising `cmd_ready_i`. The host cannot be stalled, so a new command that arrives while an entry is still offered replaces it. Back-pressure therefore never drops a byte on the serial side, but it can drop an unaccepted command. The sequencer reports activity on `seq_busy_i`. It must drop that line in the cycle after it sees the one-cycle `seq_halt_o` pulse that a general reset produces.

An interrupt flag is raised when the buffer-empty bit or the idle bit rises, and is cleared when the status byte is read. The flag pulls the open-drain request line low only while interrupts are enabled. Both open-drain and tri-state pins are shown as drive-enable outputs: a low enable means high impedance.

Top module: `vsc_host_port`

## Requirements
- R1: A byte is taken MSB first on rising serial clock edges while select is low. Raising select resets the bit count and discards a partial byte, so an aborted frame executes nothing, and the next frame decodes normally.
- R2: Command 0x60 followed by one byte sets the mode fields from bits 7..3 of that byte: bit 7 irq enable, bit 6 fast rate, bit 5 large memory, bit 4 codec powersave, bit 3 play (1) or store (0). Bits 2:0 are ignored.
- R3: Command 0x61 is followed by one reply byte, sent MSB first, with `rpl_oe_o` high for its eight bits. The byte holds: bit 7 flag, bit 6 buffer empty, bit 5 idle (not busy), bits 4:0 `pwr_i`. Each bit changes after a falling serial clock edge, and the first bit is ready before the first rising edge.
- R4: `rpl_oe_o` is low whenever no reply byte is being sent, including while select is high.
- R5: Command 0x62 followed by two bytes offers one command with `cmd_wait_o`=0 and `cmd_page_o` = {first byte, second byte}. It is offered only after the second byte arrives.
- R6: Command 0x63 offers one command with `cmd_wait_o`=1, with no data bytes.
- R7: `cmd_valid_o` stays high with a stable page and kind until the cycle in which `cmd_ready_i` is high. A new command replaces an unaccepted one. The status empty bit is the inverse of `cmd_valid_o`.
- R8: The flag sets when the empty bit or the idle bit goes from 0 to 1.
- R9: A status read reports the flag as it was, then clears it. A set event in the same cycle wins over the clear.
- R10: `irq_pull_o` is high only while both the flag and the irq enable bit are 1.
- R11: Command 0x01 clears all mode bits and the flag, flushes the buffer and pulses `seq_halt_o`. Empty and idle then read 1, and these forced edges do not set the flag.
- R12: Bytes after a completed command in the same frame are ignored, and unknown command codes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial command data |
| rpl_dat_o | output | 1 | Reply data bit |
| rpl_oe_o | output | 1 | Reply drive enable (0 = high impedance) |
| irq_pull_o | output | 1 | Interrupt pull-low enable (0 = high impedance) |
| md_irq_en_o | output | 1 | Mode: interrupt enable |
| md_fast_o | output | 1 | Mode: fast sample rate |
| md_big_o | output | 1 | Mode: single large memory |
| md_psave_o | output | 1 | Mode: codec powersave |
| md_play_o | output | 1 | Mode: play (1) or store (0) |
| pwr_i | input | 5 | Input power reading |
| cmd_valid_o | output | 1 | Command offered to sequencer |
| cmd_ready_i | input | 1 | Sequencer accepts command |
| cmd_wait_o | output | 1 | Offered command is a wait |
| cmd_page_o | output | 16 | Page word of offered command |
| seq_busy_i | input | 1 | Sequencer executing a command |
| seq_halt_o | output | 1 | One-cycle halt pulse on general reset |

## Verification
The bench aborts frames in the middle of a data byte and in the middle of a command byte. A port that kept its bit count across select would load a bogus page or misframe the next status read. It overwrites an unaccepted command and accepts one while busy, then watches the flag for both status edges with interrupts disabled and enabled. A flag that never cleared on a read, or that fired without enable, shows up in the reply byte or on the request line. A general reset is sent with a full buffer and a busy sequencer. A design that lets the forced empty or idle edges set the flag returns a status byte with bit 7 set. Trailing bytes and unknown codes are sent to catch a decoder that acts on them.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 16;
  localparam int PWR_W  = 5;
  localparam int MODE_W = 5;

  localparam logic [BYTE_W-1:0] OP_GRST = 8'h01;
  localparam logic [BYTE_W-1:0] OP_MODE = 8'h60;
  localparam logic [BYTE_W-1:0] OP_STAT = 8'h61;
  localparam logic [BYTE_W-1:0] OP_PAGE = 8'h62;
  localparam logic [BYTE_W-1:0] OP_WAIT = 8'h63;

  typedef enum logic [2:0] {
    PH_CMD, PH_MODE, PH_PGHI, PH_PGLO, PH_REPLY, PH_DONE
  } phase_e;

  typedef struct packed {
    logic irq_en;
    logic fast;
    logic big;
    logic psave;
    logic play;
  } mode_t;
endpackage

// File: rtl/vsc_sync.sv
module vsc_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/vsc_shift.sv
module vsc_shift
  import vsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_dat,
  output logic              rpl_dat,
  output logic              rpl_oe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sck_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [CNT_W-1:0]  tx_cnt;
  logic [BYTE_W-1:0] tx_sh;

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  // receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else if (csn_s) begin
      bit_cnt  <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (rise) begin
        rx_sh   <= {rx_sh[BYTE_W-3:0], sdi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          byte_vld <= 1'b1;
          byte_dat <= {rx_sh, sdi_s};
        end
      end
    end
  end

  // reply side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_cnt <= '0;
      rpl_oe <= 1'b0;
    end else if (csn_s) begin
      tx_cnt <= '0;
      rpl_oe <= 1'b0;
    end else if (tx_load) begin
      tx_sh  <= tx_byte;
      tx_cnt <= '0;
      rpl_oe <= 1'b1;
    end else if (rpl_oe) begin
      if (rise) begin
        if (tx_cnt == LAST) rpl_oe <= 1'b0;
        else                tx_cnt <= tx_cnt + 1'b1;
      end
      if (fall && tx_cnt != '0) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  assign rpl_dat = tx_sh[BYTE_W-1];

  AST_RPL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !rpl_oe); // R4
  AST_ABORT_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (bit_cnt == '0 && !byte_vld)); // R1
endmodule

// File: rtl/vsc_ctrl.sv
module vsc_ctrl
  import vsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic [PWR_W-1:0]  pwr_i,
  input  logic              cmd_ready,
  input  logic              seq_busy,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output mode_t             mode,
  output logic              cmd_valid,
  output logic              cmd_wait,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              seq_halt,
  output logic              irq_pull
);
  localparam int HI_W = PAGE_W - BYTE_W;

  phase_e          phase, ph_nxt;
  logic            gen_evt, rd_evt, ld_evt, ld_wait, mode_wr, hi_wr;
  logic [HI_W-1:0] pg_hi;
  logic            flag_q, flag_set;
  logic            emp_prev, idle_q, idle_prev;

  always_comb begin
    ph_nxt  = phase;
    gen_evt = 1'b0;
    rd_evt  = 1'b0;
    ld_evt  = 1'b0;
    ld_wait = 1'b0;
    mode_wr = 1'b0;
    hi_wr   = 1'b0;
    if (byte_vld) begin
      case (phase)
        PH_CMD: begin
          ph_nxt = PH_DONE;
          case (byte_dat)
            OP_GRST: gen_evt = 1'b1;
            OP_MODE: ph_nxt = PH_MODE;
            OP_STAT: begin rd_evt = 1'b1; ph_nxt = PH_REPLY; end
            OP_PAGE: ph_nxt = PH_PGHI;
            OP_WAIT: begin ld_evt = 1'b1; ld_wait = 1'b1; end
            default: ph_nxt = PH_DONE;
          endcase
        end
        PH_MODE:  begin mode_wr = 1'b1; ph_nxt = PH_DONE; end
        PH_PGHI:  begin hi_wr = 1'b1; ph_nxt = PH_PGLO; end
        PH_PGLO:  begin ld_evt = 1'b1; ph_nxt = PH_DONE; end
        default:  ph_nxt = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= PH_CMD;
    else if (csn_s) phase <= PH_CMD;
    else            phase <= ph_nxt;
  end

  // mode register and page assembly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      pg_hi <= '0;
    end else begin
      if (gen_evt)      mode <= '0;
      else if (mode_wr) mode <= mode_t'(byte_dat[BYTE_W-1 -: MODE_W]);
      if (hi_wr) pg_hi <= byte_dat;
    end
  end

  // one-entry command buffer, valid/ready toward the sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_wait  <= 1'b0;
      cmd_page  <= '0;
    end else if (gen_evt) begin
      cmd_valid <= 1'b0;
    end else if (ld_evt) begin
      cmd_valid <= 1'b1;
      cmd_wait  <= ld_wait;
      if (!ld_wait) cmd_page <= {pg_hi, byte_dat};
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // status bits, edge detection and interrupt flag
  assign flag_set = (~cmd_valid & ~emp_prev) | (idle_q & ~idle_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_halt  <= 1'b0;
      idle_q    <= 1'b1;
      idle_prev <= 1'b1;
      emp_prev  <= 1'b1;
      flag_q    <= 1'b0;
      tx_load   <= 1'b0;
      tx_byte   <= '0;
    end else begin
      seq_halt  <= gen_evt;
      idle_q    <= (gen_evt || seq_halt) ? 1'b1 : ~seq_busy;
      idle_prev <= gen_evt ? 1'b1 : idle_q;
      emp_prev  <= gen_evt ? 1'b1 : ~cmd_valid;
      if (gen_evt)       flag_q <= 1'b0;
      else if (flag_set) flag_q <= 1'b1;
      else if (rd_evt)   flag_q <= 1'b0;
      tx_load <= rd_evt;
      if (rd_evt) tx_byte <= {flag_q, ~cmd_valid, idle_q, pwr_i};
    end
  end

  assign irq_pull = flag_q & mode.irq_en;

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !ld_evt && !gen_evt)
      |=> (cmd_valid && $stable(cmd_page) && $stable(cmd_wait))); // R7
  AST_GRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    gen_evt |=> (mode == '0 && !flag_q && !cmd_valid && seq_halt)); // R11
  AST_GRST_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    seq_halt |=> !flag_q); // R11
  AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !flag_set && !gen_evt) |=> !flag_q); // R9
endmodule

// File: rtl/vsc_host_port.sv
module vsc_host_port
  import vsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              rpl_dat_o,
  output logic              rpl_oe_o,
  output logic              irq_pull_o,
  output logic              md_irq_en_o,
  output logic              md_fast_o,
  output logic              md_big_o,
  output logic              md_psave_o,
  output logic              md_play_o,
  input  logic [PWR_W-1:0]  pwr_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_wait_o,
  output logic [PAGE_W-1:0] cmd_page_o,
  input  logic              seq_busy_i,
  output logic              seq_halt_o
);
  logic              sck_s, sdi_s, csn_s;
  logic              byte_vld, tx_load;
  logic [BYTE_W-1:0] byte_dat, tx_byte;
  mode_t             mode;

  vsc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({csn_i, sclk_i, sdi_i}),
    .q   ({csn_s, sck_s, sdi_s})
  );

  vsc_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .csn_s    (csn_s),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .rpl_dat  (rpl_dat_o),
    .rpl_oe   (rpl_oe_o)
  );

  vsc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_s     (csn_s),
    .byte_vld  (byte_vld),
    .byte_dat  (byte_dat),
    .pwr_i     (pwr_i),
    .cmd_ready (cmd_ready_i),
    .seq_busy  (seq_busy_i),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .mode      (mode),
    .cmd_valid (cmd_valid_o),
    .cmd_wait  (cmd_wait_o),
    .cmd_page  (cmd_page_o),
    .seq_halt  (seq_halt_o),
    .irq_pull  (irq_pull_o)
  );

  assign md_irq_en_o = mode.irq_en;
  assign md_fast_o   = mode.fast;
  assign md_big_o    = mode.big;
  assign md_psave_o  = mode.psave;
  assign md_play_o   = mode.play;

  AST_IRQ_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_o |-> md_irq_en_o); // R10
endmodule

// File: tb/vsc_host_port_tb.sv
`timescale 1ns/1ps
module vsc_host_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic rpl_dat, rpl_oe, irq_pull;
  logic md_irq_en, md_fast, md_big, md_psave, md_play;
  logic [4:0] pwr = 5'h0B;
  logic cmd_valid, cmd_ready = 1'b0, cmd_wait, seq_halt;
  logic [15:0] cmd_page;
  logic busy_drv = 1'b0;
  int halt_cnt = 0, busy_mark = 0;
  logic seq_busy;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  assign seq_busy = busy_drv && (halt_cnt == busy_mark);
  always @(posedge clk) if (seq_halt) halt_cnt <= halt_cnt + 1;

  vsc_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .rpl_dat_o(rpl_dat), .rpl_oe_o(rpl_oe), .irq_pull_o(irq_pull),
    .md_irq_en_o(md_irq_en), .md_fast_o(md_fast), .md_big_o(md_big),
    .md_psave_o(md_psave), .md_play_o(md_play), .pwr_i(pwr),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_wait_o(cmd_wait),
    .cmd_page_o(cmd_page), .seq_busy_i(seq_busy), .seq_halt_o(seq_halt)
  );

  // mode write vectors: {written byte, expected {irq_en,fast,big,psave,play}}
  localparam logic [12:0] MODE_VEC [6] = '{
    {8'hF8, 5'b11111}, {8'h07, 5'b00000}, {8'h48, 5'b01001},
    {8'hA0, 5'b10100}, {8'h17, 5'b00010}, {8'h00, 5'b00000}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open();
    @(negedge clk); csn = 1'b0; idle(6);
  endtask

  task automatic frame_close();
    idle(6); csn = 1'b1; idle(10);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i]; idle(6);
      sclk = 1'b1; idle(6);
      sclk = 1'b0;
    end
  endtask

  task automatic recv_byte(output logic [7:0] r, output logic oe_ok);
    oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      idle(6);
      r[i] = rpl_dat;
      if (rpl_oe !== 1'b1) oe_ok = 1'b0;
      sclk = 1'b1; idle(6);
      sclk = 1'b0;
    end
  endtask

  task automatic read_status(string tag, logic [7:0] exp);
    logic [7:0] r;
    logic ok;
    frame_open();
    check({tag, " R4 oe low before reply"}, rpl_oe, 0);
    send_bits(8'h61, 8);
    recv_byte(r, ok);
    check({tag, " R3 status byte"}, r, exp);
    check({tag, " R3 oe held during reply"}, ok, 1);
    frame_close();
    check({tag, " R4 oe low after frame"}, rpl_oe, 0);
  endtask

  task automatic write_mode(logic [7:0] b);
    frame_open(); send_bits(8'h60, 8); send_bits(b, 8); frame_close();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(5); rst_n = 1'b1; idle(5);
    // reset state
    check("R4 reset oe", rpl_oe, 0);
    check("R10 reset irq", irq_pull, 0);
    check("R7 reset valid", cmd_valid, 0);
    check("R2 reset mode", {md_irq_en, md_fast, md_big, md_psave, md_play}, 0);
    read_status("R8 after reset no flag", 8'h6B);

    // mode vectors
    foreach (MODE_VEC[k]) begin
      write_mode(MODE_VEC[k][12:5]);
      check($sformatf("R2 mode vector %0d", k),
            {md_irq_en, md_fast, md_big, md_psave, md_play}, MODE_VEC[k][4:0]);
    end

    // page command, held under back-pressure
    frame_open(); send_bits(8'h62, 8); send_bits(8'h0A, 8);
    idle(8);
    check("R5 not offered after first byte", cmd_valid, 0);
    send_bits(8'hBC, 8); frame_close();
    check("R5 page offered", {cmd_valid, cmd_wait, cmd_page}, {1'b1, 1'b0, 16'h0ABC});
    idle(40);
    check("R7 held without ready", {cmd_valid, cmd_page}, {1'b1, 16'h0ABC});

    // wait overwrites
    frame_open(); send_bits(8'h63, 8); frame_close();
    check("R6 R7 wait overwrites", {cmd_valid, cmd_wait}, 2'b11);

    // accept while busy: empty rises, idle falls
    @(negedge clk); cmd_ready = 1'b1; busy_mark = halt_cnt; busy_drv = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    idle(4);
    check("R7 accepted", cmd_valid, 0);
    check("R10 flag without enable", irq_pull, 0);
    read_status("R8 empty edge flag", 8'hCB);
    read_status("R9 flag cleared by read", 8'h4B);

    // idle edge with interrupts enabled
    write_mode(8'h80);
    check("R10 enabled no flag", irq_pull, 0);
    @(negedge clk); busy_drv = 1'b0; idle(6);
    check("R8 R10 idle edge pulls irq", irq_pull, 1);
    read_status("R9 idle flag read", 8'hEB);
    check("R9 R10 irq released", irq_pull, 0);

    // aborted frames
    frame_open(); send_bits(8'h62, 8); send_bits(8'h12, 8); send_bits(8'h34, 4);
    csn = 1'b1; idle(10);
    check("R1 abort in data byte", cmd_valid, 0);
    frame_open(); send_bits(8'h60, 5); csn = 1'b1; idle(10);
    read_status("R1 framing resumes", 8'h6B);
    check("R1 mode untouched", md_irq_en, 1);

    // trailing bytes and unknown codes
    frame_open(); send_bits(8'h63, 8); send_bits(8'h01, 8); frame_close();
    check("R12 trailing byte ignored", {cmd_valid, cmd_wait, md_irq_en}, 3'b111);
    frame_open(); send_bits(8'h55, 8); send_bits(8'h01, 8); frame_close();
    check("R12 unknown code ignored", {cmd_valid, md_irq_en, halt_cnt[3:0]}, {2'b11, 4'd0});

    // general reset with full buffer and busy sequencer
    @(negedge clk); busy_mark = halt_cnt; busy_drv = 1'b1; idle(6);
    frame_open(); send_bits(8'h01, 8); frame_close();
    check("R11 halt pulse", halt_cnt, 1);
    check("R11 buffer flushed", cmd_valid, 0);
    check("R11 mode cleared", {md_irq_en, md_fast, md_big, md_psave, md_play}, 0);
    check("R11 irq low", irq_pull, 0);
    read_status("R11 no flag from reset", 8'h6B);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule